// File: doc/BRIEF.md
# Dual-Phase Pulse Timer

The block is a down-counting timer that produces a two-level pulse waveform. Two length registers set how many count-source strobes each half of the waveform lasts. When the counter finishes one phase, the block toggles the output and loads the counter from the other register, so the output alternates between the two levels indefinitely. Counting advances only on cycles where the count-source enable strobe is high, so a prescaler outside the block sets the time base.

A run bit in the control register arms the timer. In internal mode, counting begins as soon as the run bit is set. In external mode, counting waits for a rising edge on the trigger pin. Once the timer is running it cannot be retriggered. An invert bit flips the whole waveform, and a waveform-enable bit lets software hold the pin at its stopped level while the count continues. Each time the waveform enters its first phase, the block raises a one-cycle interrupt pulse and sets a sticky flag. Software clears that flag with a register write.

Top module: `dual_phase_timer`

## Requirements
- R1: After a synchronous active-low reset, wave_out, irq_pulse and irq_flag are 0, both length registers hold 0 and all control bits are 0.
- R2: The write port uses these addresses: 0 for the first-phase length, 1 for the second-phase length, 2 for control and 3 for flag clear. The control bits are bit 0 run, bit 1 invert, bit 2 external trigger and bit 3 waveform enable. With run=1 and external trigger=0, the edge after the control write starts the first phase and loads the first-phase length.
- R3: While running, the first phase lasts L1 strobes and the second phase lasts L2 strobes, where L1 and L2 are the register values. The phases alternate continuously.
- R4: The counter and the phase change only on clock edges where cnt_en is high. With cnt_en low the waveform holds its level.
- R5: With external trigger=1 and run=1, counting starts on the first edge where trig_in is high after being low on the previous edge. A trig_in that is already high when the timer is armed does not start it.
- R6: While running, trigger edges have no effect on the count or the waveform.
- R7: The invert bit inverts wave_out. With invert=0 the stopped level is low and the first phase is high. With invert=1 the stopped level is high and the first phase is low.
- R8: irq_pulse is high for exactly one cycle, in the cycle in which the waveform enters its first phase. That entry is a low-to-high change when invert=0 and a high-to-low change when invert=1. No other change of the waveform raises irq_pulse.
- R9: irq_flag is set by every irq_pulse and stays set until a write to address 3. If a set and a clear occur on the same edge, the set wins.
- R10: A length register written while the timer runs does not change the phase in progress. The new value is used at the next reload from that register.
- R11: Clearing the run bit stops counting on the following edge and returns wave_out to the stopped level.
- R12: A length value of 0 gives a phase of one strobe.
- R13: With waveform enable=0, wave_out stays at the stopped level while counting and irq_pulse continue as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Write data |
| cnt_en | input | 1 | Count-source enable strobe |
| trig_in | input | 1 | External start trigger (synchronous) |
| wave_out | output | 1 | Pulse waveform output |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The assertions check the following on every cycle:
- the counter never holds zero while running;
- the count and phase freeze on cycles without a strobe;
- every start lands in the first phase with an interrupt;
- a cleared run bit stops the timer on the next edge;
- the output sits at its stopped level whenever the timer is idle;
- an interrupt pulse is never longer than one cycle and always leaves the flag set.

Only the bench scenarios can show the following:
- the exact phase durations for different register values, including zero;
- the use of the old length after a rewrite in mid-phase;
- trigger edges being ignored once running;
- the refusal to start on a trigger level that is already high;
- the waveform gating that leaves interrupts running.

// File: rtl/dpt_pkg.sv
// Shared definitions for the dual-phase pulse timer: register addresses
// and the layout of the control register.
package dpt_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_LEN_A    = 2'd0,
        ADR_LEN_B    = 2'd1,
        ADR_CTRL     = 2'd2,
        ADR_FLAG_CLR = 2'd3
    } dpt_addr_e;

    // Control register, bit 3 down to bit 0.
    typedef struct packed {
        logic wave_en;
        logic ext_trig;
        logic invert;
        logic run;
    } dpt_ctrl_t;

    localparam int CTRL_W = $bits(dpt_ctrl_t);

endpackage

// File: rtl/dpt_regfile.sv
// Register file for the pulse timer. It holds both phase lengths and the
// control bits, and it decodes a write to the flag-clear address into a
// single-cycle strobe.
// Assumes CNT_W >= CTRL_W. Control bits come from the low bits of wr_data.
module dpt_regfile
    import dpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  len_a,
    output logic [CNT_W-1:0]  len_b,
    output dpt_ctrl_t         ctrl,
    output logic              flag_clr
);

    // Store written values, clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_a <= '0;
            len_b <= '0;
            ctrl  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_LEN_A: len_a <= wr_data;
                ADR_LEN_B: len_b <= wr_data;
                ADR_CTRL:  ctrl  <= dpt_ctrl_t'(wr_data[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    // The flag-clear strobe acts on the same edge as the write.
    always_comb flag_clr = wr_en && (wr_addr == ADR_FLAG_CLR);

endmodule

// File: rtl/dpt_phase_core.sv
// Phase sequencer and down-counter. Once armed and started, it loads the
// first-phase length. On each count strobe it decrements the counter. When
// a phase ends, it toggles the phase and reloads from the other register.
// Assumes trig_in is already synchronous to clk. A zero length counts as one.
module dpt_phase_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_trig,
    input  logic             trig_in,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] len_a,
    input  logic [CNT_W-1:0] len_b,
    output logic             running,
    output logic             phase_a,
    output logic [CNT_W-1:0] cnt,
    output logic             enter_a
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic trig_q;
    logic go;
    logic last;

    function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    // Start condition, end-of-phase detect and first-phase entry event.
    always_comb begin
        go      = !ext_trig || (trig_in && !trig_q);
        last    = (cnt <= ONE);
        enter_a = run && ((!running && go) ||
                          (running && cnt_en && last && !phase_a));
    end

    // Trigger history, run state, phase and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= 1'b0;
            running <= 1'b0;
            phase_a <= 1'b0;
            cnt     <= '0;
        end else begin
            trig_q <= trig_in;
            if (!run) begin
                running <= 1'b0;
                phase_a <= 1'b0;
                cnt     <= '0;
            end else if (!running) begin
                if (go) begin
                    running <= 1'b1;
                    phase_a <= 1'b1;
                    cnt     <= eff_len(len_a);
                end
            end else if (cnt_en) begin
                if (last) begin
                    phase_a <= !phase_a;
                    cnt     <= phase_a ? eff_len(len_b) : eff_len(len_a);
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/dpt_out_stage.sv
// Output stage. It forms the pin level from the phase state, the invert bit
// and the waveform enable. It also registers the interrupt pulse and keeps
// the sticky flag.
// Assumes enter_a is a single-cycle event from the phase core.
module dpt_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_a,
    input  logic running,
    input  logic phase_a,
    input  logic invert,
    input  logic wave_en,
    input  logic flag_clr,
    output logic wave_out,
    output logic irq_pulse,
    output logic irq_flag
);

    // Pin level: the stopped level, flipped while the first phase is shown.
    always_comb wave_out = invert ^ (wave_en && running && phase_a);

    // Interrupt pulse and sticky flag. Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            irq_pulse <= enter_a;
            if (enter_a)       irq_flag <= 1'b1;
            else if (flag_clr) irq_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_phase_timer.sv
// Top level of the dual-phase pulse timer. It connects the register file,
// the phase core and the output stage.
// Assumes a synchronous trigger input and an external count-enable strobe.
module dual_phase_timer
    import dpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              cnt_en,
    input  logic              trig_in,
    output logic              wave_out,
    output logic              irq_pulse,
    output logic              irq_flag
);

    logic [CNT_W-1:0] len_a;
    logic [CNT_W-1:0] len_b;
    dpt_ctrl_t        ctrl;
    logic             flag_clr;
    logic             running;
    logic             phase_a;
    logic [CNT_W-1:0] cnt;
    logic             enter_a;
    logic             ctl_run;
    logic             ctl_inv;

    // Expose the control bits that the checker watches.
    always_comb begin
        ctl_run = ctrl.run;
        ctl_inv = ctrl.invert;
    end

    dpt_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .len_a    (len_a),
        .len_b    (len_b),
        .ctrl     (ctrl),
        .flag_clr (flag_clr)
    );

    dpt_phase_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl.run),
        .ext_trig (ctrl.ext_trig),
        .trig_in  (trig_in),
        .cnt_en   (cnt_en),
        .len_a    (len_a),
        .len_b    (len_b),
        .running  (running),
        .phase_a  (phase_a),
        .cnt      (cnt),
        .enter_a  (enter_a)
    );

    dpt_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_a   (enter_a),
        .running   (running),
        .phase_a   (phase_a),
        .invert    (ctrl.invert),
        .wave_en   (ctrl.wave_en),
        .flag_clr  (flag_clr),
        .wave_out  (wave_out),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

endmodule

// File: rtl/dpt_checker.sv
// Cycle-by-cycle property checker for dual_phase_timer. It is attached to
// the top module with the bind statement at the end of this file.
module dpt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             ctl_run,
    input logic             ctl_inv,
    input logic             running,
    input logic             phase_a,
    input logic [CNT_W-1:0] cnt,
    input logic             wave_out,
    input logic             irq_pulse,
    input logic             irq_flag
);

    // R12: a running counter never holds zero.
    a_r12_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt != '0));

    // R4: without a strobe, the count and the phase are frozen.
    a_r4_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ctl_run && !cnt_en) |=> ($stable(cnt) && $stable(phase_a)));

    // R2: a start lands in the first phase and raises the interrupt.
    a_r2_start_phase_a: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (phase_a && irq_pulse));

    // R11: a cleared run bit stops the timer on the next edge.
    a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_run |=> !running);

    // R7: an idle timer shows the stopped level.
    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (wave_out == ctl_inv));

    // R8: the interrupt lasts one cycle and marks first-phase entry.
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    a_r8_irq_in_phase_a: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (running && phase_a));

    // R9: every interrupt pulse leaves the flag set.
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_flag);

endmodule

bind dual_phase_timer dpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .ctl_run   (ctl_run),
    .ctl_inv   (ctl_inv),
    .running   (running),
    .phase_a   (phase_a),
    .cnt       (cnt),
    .wave_out  (wave_out),
    .irq_pulse (irq_pulse),
    .irq_flag  (irq_flag)
);

// File: tb/dual_phase_timer_bench.sv
// Self-checking bench: a vector table of lengths and polarities walked by one
// loop, followed by directed tests for reset and corner cases.
module dual_phase_timer_bench;

    localparam int CW = 16;
    localparam int NV = 6;
    // {invert, first-phase length, second-phase length}
    localparam logic [2*CW:0] VECS [NV] = '{
        {1'b0, 16'd3, 16'd2},
        {1'b1, 16'd3, 16'd2},
        {1'b0, 16'd1, 16'd1},
        {1'b0, 16'd0, 16'd4},
        {1'b1, 16'd5, 16'd0},
        {1'b0, 16'd2, 16'd7}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          cnt_en = 1'b1;
    logic          trig_in = 1'b0;
    logic          wave_out;
    logic          irq_pulse;
    logic          irq_flag;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    dual_phase_timer #(.CNT_W(CW)) u_dual_phase_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_en    (cnt_en),
        .trig_in   (trig_in),
        .wave_out  (wave_out),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    // Control bits: [3] waveform enable, [2] external trigger, [1] invert, [0] run.
    task automatic wctl(input logic run, input logic inv, input logic ext, input logic wen);
        wr(2'd2, {{(CW-4){1'b0}}, wen, ext, inv, run});
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk("R1 wave", int'(wave_out), 0);
        chk("R1 irq", int'(irq_pulse), 0);
        chk("R1 flag", int'(irq_flag), 0);
        rst_n = 1'b1;
        tick();
        wctl(1'b1, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R1 R12 zero lengths start", int'(wave_out), 1);

        // Table walk: R3 R7 R8 R12 R2
        for (int v = 0; v < NV; v++) begin
            logic          pol;
            int            ea;
            int            eb;
            int            per;
            pol = VECS[v][2*CW];
            ea  = int'(VECS[v][2*CW-1:CW]);
            eb  = int'(VECS[v][CW-1:0]);
            if (ea == 0) ea = 1;
            if (eb == 0) eb = 1;
            per = ea + eb;
            wctl(1'b0, pol, 1'b0, 1'b1);
            wr(2'd0, VECS[v][2*CW-1:CW]);
            wr(2'd1, VECS[v][CW-1:0]);
            chk("R7 stopped level", int'(wave_out), int'(pol));
            wctl(1'b1, pol, 1'b0, 1'b1);
            chk("R2 not before start edge", int'(wave_out), int'(pol));
            for (int i = 0; i < 2 * per; i++) begin
                int pos;
                tick();
                pos = i % per;
                chk("R3 R7 R12 wave", int'(wave_out), int'(pol ^ (pos < ea)));
                chk("R8 irq", int'(irq_pulse), int'(pos == 0));
            end
        end

        // R9: sticky flag and clear
        wctl(1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R9 flag held", int'(irq_flag), 1);
        wr(2'd3, '0);
        chk("R9 flag cleared", int'(irq_flag), 0);
        tick();
        chk("R9 flag stays clear", int'(irq_flag), 0);

        // R13: waveform gated while interrupts continue
        wr(2'd0, 16'd2);
        wr(2'd1, 16'd2);
        wctl(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R13 wave held", int'(wave_out), 0);
            chk("R13 irq", int'(irq_pulse), int'(i % 4 == 0));
        end
        chk("R9 flag set again", int'(irq_flag), 1);
        wctl(1'b0, 1'b0, 1'b0, 1'b1);
        tick();

        // R4: no strobe, no count
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd3);
        cnt_en = 1'b0;
        wctl(1'b1, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R4 start", int'(wave_out), 1);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R4 hold", int'(wave_out), 1);
        end
        cnt_en = 1'b1;
        tick(); tick();
        chk("R4 resumed", int'(wave_out), 1);
        tick();
        chk("R4 phase end", int'(wave_out), 0);
        tick(); tick(); tick();
        chk("R3 back to first", int'(wave_out), 1);

        // R11: stop mid-phase
        wctl(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R11 still running", int'(wave_out), 1);
        tick();
        chk("R11 stopped", int'(wave_out), 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R11 stays stopped", int'(wave_out), 0);
        end

        // R5: external trigger start
        wr(2'd0, 16'd4);
        wr(2'd1, 16'd2);
        trig_in = 1'b0;
        wctl(1'b1, 1'b0, 1'b1, 1'b1);
        repeat (3) tick();
        chk("R5 wait trigger", int'(wave_out), 0);
        trig_in = 1'b1;
        tick();
        chk("R5 started", int'(wave_out), 1);
        chk("R5 irq", int'(irq_pulse), 1);
        // R6: edges while running are ignored
        trig_in = 1'b0;
        tick();
        trig_in = 1'b1;
        tick();
        chk("R6 irq none", int'(irq_pulse), 0);
        tick();
        chk("R6 pos3", int'(wave_out), 1);
        tick();
        chk("R6 no retrigger", int'(wave_out), 0);
        tick();
        tick();
        chk("R6 next period", int'(wave_out), 1);

        // R5: a level already high does not start
        wctl(1'b0, 1'b0, 1'b1, 1'b1);
        tick();
        trig_in = 1'b1;
        tick();
        wctl(1'b1, 1'b0, 1'b1, 1'b1);
        repeat (3) tick();
        chk("R5 level no start", int'(wave_out), 0);
        trig_in = 1'b0;
        tick();
        trig_in = 1'b1;
        tick();
        chk("R5 edge starts", int'(wave_out), 1);

        // R10: rewrite during run
        wctl(1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        wr(2'd0, 16'd4);
        wctl(1'b1, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R10 start", int'(wave_out), 1);
        wr(2'd0, 16'd1);
        tick();
        tick();
        chk("R10 old length pos3", int'(wave_out), 1);
        tick();
        chk("R10 old length end", int'(wave_out), 0);
        tick();
        tick();
        chk("R10 new length start", int'(wave_out), 1);
        chk("R10 irq", int'(irq_pulse), 1);
        tick();
        chk("R10 new length end", int'(wave_out), 0);

        finish_run();
    end

endmodule